// File: doc/BRIEF.md
# Shared Memory Port Fetch/Data Arbiter

This block decides, cycle by cycle, who owns the single memory port of a five-stage in-order pipeline. The stages run IF, ID, EX, Mem, WB. Instruction fetch and data access share one memory. When the instruction in the Mem stage is a load or a store, it takes the port. The fetch is then held. The program counter and the fetch-to-decode register keep their values, and decode receives an empty slot.

Fetch resumes on the first cycle in which the Mem stage does not need the port. If several memory-accessing instructions reach Mem in consecutive cycles, the fetch slips by one cycle for each of them. For example, a fetch blocked in three consecutive cycles happens in the fourth.

The block also steers the port address and the write strobe. When data owns the port, they come from the Mem stage. Otherwise the address is the program counter and the write strobe is low. It holds the program counter and the fetch-to-decode register, which capture the word read from the port on each granted fetch.

Top module: `umem_fetch_arb`

## Requirements
- R1: While reset is asserted, grantData and fetchEn are 0 whatever the inputs, pc equals RESET_PC and ifidValid is 0.
- R2: When memValid and memIsAccess are both 1, grantData is 1 and fetchEn is 0 in that same cycle.
- R3: When memValid is 0 or memIsAccess is 0, grantData is 0 and fetchEn equals ifValid. A valid non-memory instruction in Mem does not block fetch.
- R4: After a cycle with fetchEn at 1, pc has advanced by PC_STEP (modulo 2^ADDR_W), ifidInstr holds that cycle's memRdata and ifidValid is 1.
- R5: After a cycle with fetchEn at 0, pc and ifidInstr are unchanged and ifidValid is 0.
- R6: idBubble is 1 exactly in cycles where ifValid is 1 and the fetch is blocked by a Mem-stage access.
- R7: With N consecutive cycles of Mem-stage access and ifValid held at 1, the fetch occurs in cycle N+1. Over those N+1 cycles, pc advances by exactly one PC_STEP.
- R8: portAddr equals memDataAddr when grantData is 1, and pc otherwise.
- R9: portWe is 1 only when grantData is 1 and memIsStore is 1. memIsStore has no effect without a granted data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ifValid | input | 1 | Fetch stage wants to fetch this cycle |
| memValid | input | 1 | Mem stage holds a valid instruction |
| memIsAccess | input | 1 | Mem-stage instruction is a load or store |
| memIsStore | input | 1 | Mem-stage access is a store |
| memDataAddr | input | ADDR_W | Data address from the Mem stage |
| memRdata | input | DATA_W | Word read from the shared port |
| grantData | output | 1 | Port owned by the Mem stage this cycle |
| fetchEn | output | 1 | Port owned by fetch; pc and IF/ID update |
| idBubble | output | 1 | Fetch stalled by conflict; ID gets a bubble |
| portAddr | output | ADDR_W | Address driven onto the shared port |
| portWe | output | 1 | Write strobe onto the shared port |
| pc | output | ADDR_W | Program counter |
| ifidInstr | output | DATA_W | Instruction held in the IF/ID register |
| ifidValid | output | 1 | IF/ID register holds a valid instruction |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=16, PC_STEP=4 and RESET_PC=8'hF0. With these values the program counter wraps past 8'hFC within a handful of fetches. The directed scenarios therefore reach the wrap of the step adder as well as the hold and advance behaviour around load/store runs. The narrow data word keeps the distinct instruction patterns easy to tell apart when checking which read word was captured on the one granted cycle after a stall.

// File: rtl/umem_arb_pkg.sv
package umem_arb_pkg;
  typedef struct packed {
    logic grantData;
    logic fetchEn;
    logic bubble;
  } arbStrobes_t;
endpackage

// File: rtl/umem_arb_ctrl.sv
module umem_arb_ctrl
  import umem_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ifValid,
  input  logic        memValid,
  input  logic        memIsAccess,
  output arbStrobes_t strobes
);
  logic dataReq;

  // Older Mem-stage access always wins the port over fetch.
  always_comb begin
    dataReq           = memValid & memIsAccess;
    strobes.grantData = rstN & dataReq;
    strobes.fetchEn   = rstN & ifValid & ~dataReq;
    strobes.bubble    = rstN & ifValid & dataReq;
  end

  assert_data_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memIsAccess) |-> (strobes.grantData && !strobes.fetchEn));

  assert_no_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ifValid && !(memValid && memIsAccess)) |-> strobes.fetchEn);

endmodule

// File: rtl/umem_arb_datapath.sv
module umem_arb_datapath
  import umem_arb_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 32,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strobes,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] memDataAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portWe,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ifidInstr,
  output logic              ifidValid
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] instrQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= RESET_PC;
      instrQ <= '0;
      validQ <= 1'b0;
    end else if (strobes.fetchEn) begin
      pcQ    <= pcQ + STEP;
      instrQ <= memRdata;
      validQ <= 1'b1;
    end else begin
      validQ <= 1'b0;
    end
  end

  always_comb begin
    portAddr  = strobes.grantData ? memDataAddr : pcQ;
    portWe    = strobes.grantData & memIsStore;
    pc        = pcQ;
    ifidInstr = instrQ;
    ifidValid = validQ;
  end

  assert_pc_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchEn |=> (pcQ == $past(pcQ) + STEP) && validQ);

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fetchEn |=> $stable(pcQ) && $stable(instrQ) && !validQ);

  assert_bubble_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bubble |=> !validQ);

endmodule

// File: rtl/umem_fetch_arb.sv
module umem_fetch_arb
  import umem_arb_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 32,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifValid,
  input  logic              memValid,
  input  logic              memIsAccess,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] memDataAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              grantData,
  output logic              fetchEn,
  output logic              idBubble,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portWe,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ifidInstr,
  output logic              ifidValid
);
  arbStrobes_t strobes;

  umem_arb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .memValid(memValid),
    .memIsAccess(memIsAccess), .strobes(strobes)
  );

  umem_arb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memIsStore(memIsStore),
    .memDataAddr(memDataAddr), .memRdata(memRdata), .portAddr(portAddr),
    .portWe(portWe), .pc(pc), .ifidInstr(ifidInstr), .ifidValid(ifidValid)
  );

  always_comb begin
    grantData = strobes.grantData;
    fetchEn   = strobes.fetchEn;
    idBubble  = strobes.bubble;
  end

  assert_reset_port_R1: assert property (@(posedge clk)
    !rstN |-> (!grantData && !fetchEn));

endmodule

// File: tb/sim_umem_fetch_arb.sv
module sim_umem_fetch_arb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RST_PC = 8'hF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ifValid = 1'b0, memValid = 1'b0, memIsAccess = 1'b0, memIsStore = 1'b0;
  logic [7:0]  memDataAddr = '0;
  logic [15:0] memRdata = '0;
  logic        grantData, fetchEn, idBubble, portWe, ifidValid;
  logic [7:0]  portAddr, pc;
  logic [15:0] ifidInstr;

  int checks = 0;
  int errors = 0;
  logic [7:0]  expPc = RST_PC;
  logic [15:0] expInstr = '0;
  logic        expValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  umem_fetch_arb #(.ADDR_W(8), .DATA_W(16), .PC_STEP(4), .RESET_PC(RST_PC)) u0 (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .memValid(memValid),
    .memIsAccess(memIsAccess), .memIsStore(memIsStore), .memDataAddr(memDataAddr),
    .memRdata(memRdata), .grantData(grantData), .fetchEn(fetchEn), .idBubble(idBubble),
    .portAddr(portAddr), .portWe(portWe), .pc(pc), .ifidInstr(ifidInstr),
    .ifidValid(ifidValid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Entered at a falling edge; drives, checks port side, crosses one rising edge,
  // checks registered state at the next falling edge.
  task automatic step(input logic ifv, input logic mv, input logic acc, input logic st,
                      input logic [7:0] da, input logic [15:0] rd);
    logic dReq, eFetch;
    ifValid = ifv; memValid = mv; memIsAccess = acc; memIsStore = st;
    memDataAddr = da; memRdata = rd;
    #1;
    dReq   = mv & acc;
    eFetch = ifv & ~dReq;
    chk(dReq ? "R2" : "R3", "grantData", 32'(grantData), 32'(dReq));
    chk(dReq ? "R2" : "R3", "fetchEn", 32'(fetchEn), 32'(eFetch));
    chk("R6", "idBubble", 32'(idBubble), 32'(ifv & dReq));
    chk("R8", "portAddr", 32'(portAddr), 32'(dReq ? da : expPc));
    chk("R9", "portWe", 32'(portWe), 32'(dReq & st));
    @(posedge clk);
    if (eFetch) begin
      expPc = expPc + 8'd4; expInstr = rd; expValid = 1'b1;
    end else begin
      expValid = 1'b0;
    end
    @(negedge clk);
    chk(eFetch ? "R4" : "R5", "pc", 32'(pc), 32'(expPc));
    chk(eFetch ? "R4" : "R5", "ifidInstr", 32'(ifidInstr), 32'(expInstr));
    chk(eFetch ? "R4" : "R5", "ifidValid", 32'(ifidValid), 32'(expValid));
  endtask

  task automatic t_reset_R1();
    rstN = 1'b0; ifValid = 1'b1; memValid = 1'b1; memIsAccess = 1'b1; memIsStore = 1'b1;
    @(negedge clk); #1;
    chk("R1", "grantData in reset", 32'(grantData), 32'd0);
    chk("R1", "fetchEn in reset", 32'(fetchEn), 32'd0);
    chk("R1", "pc in reset", 32'(pc), 32'(RST_PC));
    chk("R1", "ifidValid in reset", 32'(ifidValid), 32'd0);
    chk("R9", "portWe in reset", 32'(portWe), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    expPc = RST_PC; expInstr = '0; expValid = 1'b0;
  endtask

  task automatic t_plain_fetch_R4();
    step(1, 0, 0, 0, 8'h11, 16'hA001);
    step(1, 0, 0, 0, 8'h12, 16'hA002);
    step(1, 0, 0, 0, 8'h13, 16'hA003);
  endtask

  task automatic t_load_stall_R5();
    step(1, 1, 1, 0, 8'h40, 16'hDEAD);
    step(1, 0, 0, 0, 8'h41, 16'hB004);
  endtask

  task automatic t_back_to_back_R7();
    logic [7:0] pcStart;
    pcStart = expPc;
    step(1, 1, 1, 0, 8'h50, 16'hC001);
    chk("R7", "no fetch in blocked cycle 1", 32'(pc), 32'(pcStart));
    step(1, 1, 1, 1, 8'h51, 16'hC002);
    chk("R7", "no fetch in blocked cycle 2", 32'(pc), 32'(pcStart));
    step(1, 1, 1, 0, 8'h52, 16'hC003);
    chk("R7", "no fetch in blocked cycle 3", 32'(pc), 32'(pcStart));
    step(1, 0, 0, 0, 8'h53, 16'hC004);
    chk("R7", "single fetch in cycle 4", 32'(pc), 32'(pcStart + 8'd4));
    chk("R7", "captured word", 32'(ifidInstr), 32'h0000C004);
  endtask

  task automatic t_non_mem_R3();
    step(1, 1, 0, 0, 8'h60, 16'hD001);  // ALU/branch in Mem
    step(1, 0, 1, 1, 8'h61, 16'hD002);  // flag without valid
    step(0, 0, 0, 0, 8'h62, 16'hD003);  // fetch idle
  endtask

  task automatic t_store_port_R9();
    step(0, 1, 1, 1, 8'h77, 16'hE001);  // store, fetch idle: no bubble
    step(1, 0, 0, 1, 8'h78, 16'hE002);  // store flag without access ignored
    chk("R9", "ifidInstr after ignored store flag", 32'(ifidInstr), 32'h0000E002);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_plain_fetch_R4();
    t_load_stall_R5();
    t_back_to_back_R7();
    t_non_mem_R3();
    t_store_port_R9();
    t_plain_fetch_R4();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule